// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers interrupt sources for a small 8-bit processor core and decides which one the core should service. Each source has a latched request bit and an enable bit. A global disable flag, held here on behalf of the core's status word, masks every source except the software break. The block presents one pending request, `irq_o`, and the index of the winning source, `idx_o`, which the core uses to select a vector. The core confirms service with a one-cycle `ack_i` pulse. In that cycle the winning request bit is cleared, the disable flag is copied into a saved copy, and the flag is forced to 1.

Two external pins feed sources 0 and 1 through a two-flop synchronizer and an edge detector. The polarity of each pin is programmable. A group of key pins, which idle high, can raise source 2 on a falling edge of any key when key wake-up is enabled. The other sources come from on-chip event pulses on `evt_i`.

A small register bus gives software access to the requests, the enables, the edge/wake-up selection and a read-only status word. Software can clear a request bit but can never set one. The set-disable, clear-disable and return-from-interrupt operations of the core drive the flag directly.

Top module: `irq_ctrl`

## Requirements
- R1: A one-cycle `evt_i[k]` pulse sets request bit k on that clock edge. The bit then holds at 1 until it is accepted or cleared by software.
- R2: Writing the request register (address 0) clears every bit written as 0 and leaves every bit written as 1 unchanged. Software can never set a request bit.
- R3: When a hardware event and a software clear hit the same request bit in the same cycle, the bit ends at 1.
- R4: A source whose enable bit (address 1, bit k) is 0 still latches its request, but never drives `irq_o`.
- R5: While the disable flag is 1, no maskable request drives `irq_o`. A `brk_i` pulse latches a break request that drives `irq_o` regardless of the flag.
- R6: Among pending, enabled requests the lowest index wins and appears on `idx_o`. A pending break beats every source and shows `idx_o` = N_SRC (8).
- R7: On `ack_i`, the winning request (or the break request) is cleared, `saved_flag_o` takes the flag value from before the pulse, and the flag becomes 1.
- R8: `sei_i` sets the flag and `cli_i` clears it. `rti_i` loads the flag from `rti_flag_i`. When several of these arrive together, the priority is ack, then rti, then sei, then cli.
- R9: Address 2 bits 0 and 1 select the polarity for external pins 0 and 1 (0 = falling, 1 = rising). An edge of the selected polarity sets request bit 0 or 1 within four cycles. The opposite edge sets nothing.
- R10: Address 2 bit 2 enables key wake-up. While it is 1, a falling edge on any key pin sets request bit 2. While it is 0, key edges set nothing.
- R11: After reset, requests, enables, the selection register, the break request and the saved flag are 0, the disable flag is 1, and `irq_o` is 0.
- R12: The status register (address 3) reads the disable flag in bit 2 and the saved flag in bit 3. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_SRC | On-chip event pulses, one per source |
| ext_pin_i | input | N_EXT | Asynchronous external interrupt pins |
| key_pin_i | input | N_KEY | Asynchronous key pins, idle high |
| brk_i | input | 1 | Software break request pulse |
| sei_i | input | 1 | Set-disable operation |
| cli_i | input | 1 | Clear-disable operation |
| rti_i | input | 1 | Return-from-interrupt: reload the flag |
| rti_flag_i | input | 1 | Flag value restored by return-from-interrupt |
| ack_i | input | 1 | One-cycle accept pulse from the core |
| irq_o | output | 1 | A request is presented to the core |
| idx_o | output | IDX_W | Index of the winning source, N_SRC for break |
| saved_flag_o | output | 1 | Flag value captured at the last accept |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
The assertions assume that the core pulses `ack_i` only while `irq_o` is high, and for a single cycle. They also assume that the set-disable, clear-disable and return operations are single-cycle strobes. The bench drives `ack_i` only after it has seen `irq_o` high at a falling clock edge. Every core operation lasts exactly one clock. Pin and key changes are spaced at least four cycles apart, so the synchronizer delay never overlaps two edges. Event pulses and register writes are aligned to falling edges, so each change lands on a single known rising edge.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    ADDR_REQ  = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_SEL  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_DIS_BIT = 2;
  localparam int unsigned STAT_SAV_BIT = 3;
endpackage

// File: rtl/irq_sync_edge.sv
`timescale 1ns/1ps
module irq_sync_edge #(
  parameter int unsigned W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pol_i,   // 1: rising, 0: falling
  output logic [W-1:0] edge_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= RST_VAL[g];
        s2_q   <= RST_VAL[g];
        prev_q <= RST_VAL[g];
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign edge_o[g] = pol_i[g] ? (s2_q & ~prev_q) : (~s2_q & prev_q);
  end
endmodule

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         req_o[g] <= 1'b0;
      else if (set_i[g])                   req_o[g] <= 1'b1;  // hardware wins
      else if (sw_clr_i[g] || ack_clr_i[g]) req_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     en_i,
  input  logic             allow_i,
  input  logic             brk_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(N);

  logic [N-1:0] cand;
  logic         found;

  always_comb begin
    cand  = req_i & en_i & {N{allow_i}};
    found = 1'b0;
    oh_o  = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !found) begin
        found   = 1'b1;
        oh_o[i] = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
    if (brk_i) begin
      oh_o  = '0;
      idx_o = BRK_IDX;
    end
    vld_o = brk_i | found;
  end
endmodule

// File: rtl/irq_flag.sv
`timescale 1ns/1ps
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic rti_i,
  input  logic rti_flag_i,
  input  logic sei_i,
  input  logic cli_i,
  output logic flag_o,
  output logic saved_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b1;
      saved_o <= 1'b0;
    end else if (ack_i) begin
      saved_o <= flag_o;
      flag_o  <= 1'b1;
    end else if (rti_i) begin
      flag_o  <= rti_flag_i;
    end else if (sei_i) begin
      flag_o  <= 1'b1;
    end else if (cli_i) begin
      flag_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_pkg::*;
#(
  parameter  int unsigned N_SRC   = 8,
  parameter  int unsigned N_EXT   = 2,
  parameter  int unsigned N_KEY   = 4,
  parameter  int unsigned KEY_SRC = 2,
  localparam int unsigned IDX_W   = $clog2(N_SRC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_KEY-1:0]  key_pin_i,
  input  logic              brk_i,
  input  logic              sei_i,
  input  logic              cli_i,
  input  logic              rti_i,
  input  logic              rti_flag_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              saved_flag_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o
);
  localparam int unsigned KEY_EN_BIT = N_EXT;

  logic [N_SRC-1:0] req_q, en_q, hw_set, sw_clr, ack_clr, win_oh;
  logic [N_EXT-1:0] pol_q, ext_edge;
  logic [N_KEY-1:0] key_edge;
  logic             kwu_q, flag_q, saved_q, brk_q;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             wr_req, wr_en, wr_sel;

  assign wr_req = reg_we_i && (reg_addr_i == ADDR_REQ);
  assign wr_en  = reg_we_i && (reg_addr_i == ADDR_EN);
  assign wr_sel = reg_we_i && (reg_addr_i == ADDR_SEL);

  irq_sync_edge #(.W(N_EXT), .RST_VAL('0)) u_ext (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .pol_i(pol_q), .edge_o(ext_edge)
  );

  irq_sync_edge #(.W(N_KEY), .RST_VAL('1)) u_key (
    .clk_i, .rst_ni, .pin_i(key_pin_i), .pol_i('0), .edge_o(key_edge)
  );

  always_comb begin
    hw_set                 = evt_i;
    hw_set[N_EXT-1:0]      = hw_set[N_EXT-1:0] | ext_edge;
    hw_set[KEY_SRC]        = hw_set[KEY_SRC] | (kwu_q & (|key_edge));
  end

  assign sw_clr  = wr_req ? ~reg_wdata_i[N_SRC-1:0] : '0;
  assign ack_clr = ack_i ? win_oh : '0;

  irq_req_bank #(.N(N_SRC)) u_req (
    .clk_i, .rst_ni, .set_i(hw_set), .sw_clr_i(sw_clr),
    .ack_clr_i(ack_clr), .req_o(req_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
      kwu_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= reg_wdata_i[N_SRC-1:0];
      if (wr_sel) begin
        pol_q <= reg_wdata_i[N_EXT-1:0];
        kwu_q <= reg_wdata_i[KEY_EN_BIT];
      end
    end
  end

  // break request: set wins over its own accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            brk_q <= 1'b0;
    else if (brk_i)         brk_q <= 1'b1;
    else if (ack_i)         brk_q <= 1'b0;
  end

  irq_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i(req_q), .en_i(en_q), .allow_i(~flag_q), .brk_i(brk_q),
    .vld_o(win_vld), .idx_o(win_idx), .oh_o(win_oh)
  );

  irq_flag u_flag (
    .clk_i, .rst_ni, .ack_i, .rti_i, .rti_flag_i, .sei_i, .cli_i,
    .flag_o(flag_q), .saved_o(saved_q)
  );

  assign irq_o        = win_vld;
  assign idx_o        = win_idx;
  assign saved_flag_o = saved_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_REQ: reg_rdata_o[N_SRC-1:0] = req_q;
      ADDR_EN:  reg_rdata_o[N_SRC-1:0] = en_q;
      ADDR_SEL: begin
        reg_rdata_o[N_EXT-1:0]  = pol_q;
        reg_rdata_o[KEY_EN_BIT] = kwu_q;
      end
      default: begin
        reg_rdata_o[STAT_DIS_BIT] = flag_q;
        reg_rdata_o[STAT_SAV_BIT] = saved_q;
      end
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic [IDX_W-1:0] idx_o,
  input logic             ack_i,
  input logic             sei_i,
  input logic             cli_i,
  input logic             rti_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             flag_i,
  input logic             saved_i,
  input logic             brk_i,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] en_i
);
  localparam logic [IDX_W-1:0] BRK_IDX = IDX_W'(N_SRC);

  logic [N_SRC-1:0] req_sh, en_sh;
  assign req_sh = req_i >> idx_o;
  assign en_sh  = en_i >> idx_o;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i && !(reg_we_i && reg_addr_i == 2'd0) |=> (($past(req_i) & ~req_i) == '0)); // R1
  AST_WINNER_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && idx_o != BRK_IDX |-> req_sh[0] && en_sh[0]); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !brk_i |-> !irq_o); // R5
  AST_BRK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> irq_o && idx_o == BRK_IDX); // R6
  AST_ACK_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> flag_i); // R7
  AST_ACK_SAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> saved_i == $past(flag_i)); // R7
  AST_CLI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cli_i && !ack_i && !rti_i && !sei_i |=> !flag_i); // R8
  AST_SEI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sei_i && !rti_i |=> flag_i); // R8
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .idx_o(idx_o),
  .ack_i(ack_i), .sei_i(sei_i), .cli_i(cli_i), .rti_i(rti_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .flag_i(flag_q), .saved_i(saved_q), .brk_i(brk_q),
  .req_i(req_q), .en_i(en_q)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  localparam int N = 8;

  logic       clk_i = 0, rst_ni = 0;
  logic [7:0] evt_i = '0;
  logic [1:0] ext_pin_i = '0;
  logic [3:0] key_pin_i = '1;
  logic       brk_i = 0, sei_i = 0, cli_i = 0, rti_i = 0, rti_flag_i = 0, ack_i = 0;
  logic       irq_o, saved_flag_o;
  logic [3:0] idx_o;
  logic       reg_we_i = 0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;

  int nvec = 0, nerr = 0;

  always #10 clk_i = ~clk_i;

  irq_ctrl u0 (.*);

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic int lowbit(input int v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return N;
  endfunction

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr_i = a; #1; d = int'(reg_rdata_o);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i); reg_we_i = 0; #1;
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk_i); evt_i = m;
    @(posedge clk_i); @(negedge clk_i); evt_i = '0; #1;
  endtask

  // op: 0 sei, 1 cli, 2 rti, 3 ack, 4 brk
  task automatic op(input int k, input logic f);
    @(negedge clk_i);
    case (k)
      0: sei_i = 1;
      1: cli_i = 1;
      2: begin rti_i = 1; rti_flag_i = f; end
      3: ack_i = 1;
      default: brk_i = 1;
    endcase
    @(posedge clk_i); @(negedge clk_i);
    sei_i = 0; cli_i = 0; rti_i = 0; ack_i = 0; brk_i = 0; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1; #1;

    // R11 / R12 reset state
    rd(2'd0, d); chk("R11 req", d, 0);
    rd(2'd1, d); chk("R11 en", d, 0);
    rd(2'd2, d); chk("R11 sel", d, 0);
    rd(2'd3, d); chk("R12 stat", d, 8'h04);
    chk("R11 irq", int'(irq_o), 0);

    // R1 latch and hold
    pulse_evt(8'h20);
    rd(2'd0, d); chk("R1 set", d, 8'h20);
    idle(5);
    rd(2'd0, d); chk("R1 hold", d, 8'h20);

    // R2 software cannot set, writing 0 clears
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 no set", d, 8'h20);
    wr(2'd0, 8'hDF); rd(2'd0, d); chk("R2 clear", d, 8'h00);

    // R3 hardware set beats software clear
    pulse_evt(8'h08);
    @(negedge clk_i); evt_i = 8'h08; reg_we_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 8'h00;
    @(posedge clk_i); @(negedge clk_i); evt_i = 0; reg_we_i = 0; #1;
    rd(2'd0, d); chk("R3 hw wins", d, 8'h08);
    wr(2'd0, 8'h00);

    // R4 disabled source latches but stays silent
    op(1, 0);
    pulse_evt(8'h10);
    chk("R4 silent", int'(irq_o), 0);
    rd(2'd0, d); chk("R4 latched", d, 8'h10);
    wr(2'd0, 8'h00);

    // R6 priority sweep over all request patterns
    wr(2'd1, 8'hFF);
    for (int m = 1; m < 256; m++) begin
      pulse_evt(8'(m));
      chk("R6 irq", int'(irq_o), 1);
      chk("R6 idx", int'(idx_o), lowbit(m));
      wr(2'd0, 8'h00);
    end

    // R4 sweep over all enable patterns
    pulse_evt(8'hFF);
    for (int e = 0; e < 256; e++) begin
      wr(2'd1, 8'(e));
      chk("R4 irq", int'(irq_o), (e != 0) ? 1 : 0);
      if (e != 0) chk("R4 idx", int'(idx_o), lowbit(e));
    end
    wr(2'd1, 8'hFF);

    // R5 flag masks, break ignores it
    op(0, 0);
    chk("R5 masked", int'(irq_o), 0);
    op(4, 0);
    chk("R5 brk irq", int'(irq_o), 1);
    chk("R6 brk idx", int'(idx_o), N);
    op(3, 0);
    chk("R5 brk cleared", int'(irq_o), 0);
    rd(2'd0, d); chk("R7 brk keeps req", d, 8'hFF);

    // R7 drain in priority order
    for (int k = 0; k < N; k++) begin
      op(1, 0);
      chk("R7 idx", int'(idx_o), k);
      op(3, 0);
      rd(2'd0, d); chk("R7 req cleared", d, (8'hFF << (k + 1)) & 8'hFF);
      rd(2'd3, d); chk("R7 flag set", (d >> 2) & 1, 1);
      chk("R7 saved", int'(saved_flag_o), 0);
    end

    // R8 flag operations
    op(2, 0); rd(2'd3, d); chk("R8 rti 0", (d >> 2) & 1, 0);
    op(0, 0); rd(2'd3, d); chk("R8 sei", (d >> 2) & 1, 1);
    op(1, 0); rd(2'd3, d); chk("R8 cli", (d >> 2) & 1, 0);
    op(2, 1); rd(2'd3, d); chk("R8 rti 1", (d >> 2) & 1, 1);

    // R9 external pin polarity
    @(negedge clk_i); ext_pin_i[0] = 1; idle(5);
    rd(2'd0, d); chk("R9 wrong edge", d, 0);
    @(negedge clk_i); ext_pin_i[0] = 0; idle(5);
    rd(2'd0, d); chk("R9 falling", d, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R12 sel rd", d, 8'h03);
    @(negedge clk_i); ext_pin_i[1] = 1; idle(5);
    rd(2'd0, d); chk("R9 rising", d, 8'h02);
    wr(2'd0, 8'h00);
    @(negedge clk_i); ext_pin_i[1] = 0; idle(5);
    rd(2'd0, d); chk("R9 fall ignored", d, 0);

    // R10 key wake-up
    @(negedge clk_i); key_pin_i[1] = 0; idle(5);
    rd(2'd0, d); chk("R10 disabled", d, 0);
    @(negedge clk_i); key_pin_i[1] = 1; idle(5);
    wr(2'd2, 8'h04);
    @(negedge clk_i); key_pin_i[3] = 0; idle(5);
    rd(2'd0, d); chk("R10 wake", d, 8'h04);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule